// File: doc/BRIEF.md
# Halt Power Sequencer

This block steps a small processor core between normal running, a deep halt and a lighter "active" halt. It watches the executed instruction stream. When the halt opcode retires, it chooses the halt depth from the timer wake-up configuration. It drops the core and peripheral clock enables, and it pulses a request to clear the core's interrupt mask so that a wake-up interrupt can be taken.

In active halt, the oscillator enable and the wake-up timer clock enable stay on, and any pending interrupt brings the core back. In plain halt, every enable goes low and only an external interrupt or a reset event can wake the core. An interrupt wake-up returns to running on the next cycle and asks for that interrupt's vector. A reset wake-up first counts a start-up delay with the oscillator on, then asks for the reset vector.

The watchdog interacts with halting as follows. If the watchdog is running and active halt is not configured, a halt instruction raises a watchdog reset request instead of halting. If active halt is configured, no such request is made.

Top module: `halt_power_ctrl`

## Requirements
- R1: A halt is requested only when `instr_valid_i` is high in the running state with `instr_op_i` equal to 8'h8E. The new state shows from the next cycle. Other opcodes, and halt opcodes seen outside the running state, change nothing.
- R2: `state_o` encodes running as 0, plain halt as 1, active halt as 2 and start-up delay as 3. Reset leaves the block running. Active halt is chosen when `tb_ie_i`, `ovf_ie_i` or any bit of `ck_sel_i` is set. When all of them are zero, plain halt is chosen.
- R3: `imask_clr_o` is high for exactly the first cycle spent in either halt state.
- R4: In running, all four enables are high. In active halt, only `osc_ce_o` and `tmr_ce_o` are high.
- R5: In plain halt, all four enables are low. `irq_pend_i` alone does not end plain halt; `ext_irq_i` does.
- R6: In active halt, `irq_pend_i` or `ext_irq_i` returns the block to running on the next cycle, with `vec_irq_o` high for that first running cycle. If the interrupt is already pending when the halt is entered, the halt state lasts one cycle.
- R7: `rst_wake_i` moves the block from any state into start-up delay. The delay lasts 256 cycles when `dly_long_i` is 0 and 4096 cycles when it is 1. The block then returns to running with `vec_rst_o` high for one cycle.
- R8: A halt opcode with `wdg_active_i` high and active halt not configured keeps the block running and pulses `wdg_rst_o` one cycle later. With active halt configured, the block enters active halt and `wdg_rst_o` stays low.
- R9: During start-up delay, only `osc_ce_o` is high.
- R10: A `rst_wake_i` received during start-up delay clears the count, so that the full delay is counted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| instr_valid_i | input | 1 | An instruction retires this cycle |
| instr_op_i | input | OP_W | Opcode of the retiring instruction |
| tb_ie_i | input | 1 | Timebase wake-up interrupt enable |
| ovf_ie_i | input | 1 | Timer overflow wake-up interrupt enable |
| ck_sel_i | input | CKS_W | Wake-up timer clock select |
| wdg_active_i | input | 1 | Watchdog is running |
| irq_pend_i | input | 1 | Any interrupt is pending |
| ext_irq_i | input | 1 | An external interrupt is pending |
| rst_wake_i | input | 1 | Reset event |
| dly_long_i | input | 1 | Static choice: 0 selects the short start-up delay, 1 the long one |
| cpu_ce_o | output | 1 | Core clock enable |
| per_ce_o | output | 1 | Peripheral clock enable |
| osc_ce_o | output | 1 | Main oscillator enable |
| tmr_ce_o | output | 1 | Wake-up timer counter clock enable |
| imask_clr_o | output | 1 | One-cycle request to clear the interrupt mask |
| vec_irq_o | output | 1 | One-cycle request to fetch the waking interrupt's vector |
| vec_rst_o | output | 1 | One-cycle request to fetch the reset vector |
| wdg_rst_o | output | 1 | One-cycle watchdog reset request |
| state_o | output | 2 | Current power state |

## Verification
The assertions assume that `dly_long_i` and the timer configuration bits stay steady while a halt or a delay is in progress. They also assume that every input has a known value once reset is released. The stimulus changes configuration only while the block is running, and it holds every input at a defined level from time zero. It drives one-cycle `rst_wake_i` pulses, including one in the middle of a long delay. Interrupt lines are raised both before and after halt entry, so that the immediate wake-up and the plain-halt masking of non-external interrupts are both reached.

// File: rtl/halt_pkg.sv
package halt_pkg;
   typedef enum logic [1:0] {
      PS_RUN   = 2'b00,
      PS_HALT  = 2'b01,
      PS_AHALT = 2'b10,
      PS_DELAY = 2'b11
   } pstate_e;

   typedef struct packed {
      logic cpu;
      logic per;
      logic osc;
      logic tmr;
   } clk_en_t;
endpackage

// File: rtl/halt_mode_sel.sv
module halt_mode_sel #(
   parameter int          OP_W      = 8,
   parameter logic [7:0]  HALT_OP   = 8'h8E,
   parameter int          CKS_W     = 2,
   parameter bit          HAS_AHALT = 1'b1
) (
   input  logic             in_run,
   input  logic             instr_valid,
   input  logic [OP_W-1:0]  instr_op,
   input  logic             tb_ie,
   input  logic             ovf_ie,
   input  logic [CKS_W-1:0] ck_sel,
   input  logic             wdg_active,
   output logic             go_halt,
   output logic             go_active,
   output logic             wdg_trip
);
   localparam logic [OP_W-1:0] OP_MATCH = OP_W'(HALT_OP);

   logic hit;
   logic active_en;

   if (OP_W < 1) begin : g_bad_opw
      $error("halt_mode_sel: OP_W must be positive");
   end
   if (CKS_W < 1) begin : g_bad_cksw
      $error("halt_mode_sel: CKS_W must be positive");
   end

   if (HAS_AHALT) begin : g_ahalt
      assign active_en = tb_ie | ovf_ie | (|ck_sel);
   end else begin : g_plain_only
      logic unused_cfg;
      assign unused_cfg = tb_ie ^ ovf_ie ^ (^ck_sel);
      assign active_en  = 1'b0;
   end

   assign hit       = in_run & instr_valid & (instr_op == OP_MATCH);
   assign wdg_trip  = hit & wdg_active & ~active_en;
   assign go_halt   = hit & ~wdg_trip;
   assign go_active = go_halt & active_en;
endmodule

// File: rtl/halt_startup_cnt.sv
module halt_startup_cnt #(
   parameter int SHORT_CYC = 256,
   parameter int LONG_CYC  = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic running,
   input  logic long_sel,
   output logic done
);
   localparam int               CNT_W      = $clog2(LONG_CYC);
   localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_CYC - 1);
   localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_CYC - 1);

   if (SHORT_CYC < 2) begin : g_bad_short
      $error("halt_startup_cnt: SHORT_CYC must be at least 2");
   end
   if (LONG_CYC <= SHORT_CYC) begin : g_bad_long
      $error("halt_startup_cnt: LONG_CYC must exceed SHORT_CYC");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last;

   assign last = long_sel ? LONG_LAST : SHORT_LAST;
   assign done = running & (cnt_q == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (clear)            cnt_q <= '0;
      else if (running && !done) cnt_q <= cnt_q + 1'b1;
   end

   // R7: the count never passes the selected limit
   a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (cnt_q <= last));
   // R10: a clear restarts the count from zero
   a_r10_clear_restart: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (cnt_q == '0));
endmodule

// File: rtl/halt_clk_en.sv
module halt_clk_en
   import halt_pkg::*;
#(
   parameter bit OSC_IN_DELAY = 1'b1
) (
   input  pstate_e st,
   output clk_en_t en
);
   logic osc_dly;

   if (OSC_IN_DELAY) begin : g_osc_dly_on
      assign osc_dly = 1'b1;
   end else begin : g_osc_dly_off
      assign osc_dly = 1'b0;
   end

   always_comb begin
      en = '0;
      unique case (st)
         PS_RUN:   en = '{cpu: 1'b1, per: 1'b1, osc: 1'b1, tmr: 1'b1};
         PS_HALT:  en = '0;
         PS_AHALT: en = '{cpu: 1'b0, per: 1'b0, osc: 1'b1, tmr: 1'b1};
         PS_DELAY: en = '{cpu: 1'b0, per: 1'b0, osc: osc_dly, tmr: 1'b0};
         default:  en = '0;
      endcase
   end
endmodule

// File: rtl/halt_power_ctrl.sv
module halt_power_ctrl
   import halt_pkg::*;
#(
   parameter int         OP_W      = 8,
   parameter logic [7:0] HALT_OP   = 8'h8E,
   parameter int         CKS_W     = 2,
   parameter bit         HAS_AHALT = 1'b1,
   parameter int         SHORT_CYC = 256,
   parameter int         LONG_CYC  = 4096
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             instr_valid_i,
   input  logic [OP_W-1:0]  instr_op_i,
   input  logic             tb_ie_i,
   input  logic             ovf_ie_i,
   input  logic [CKS_W-1:0] ck_sel_i,
   input  logic             wdg_active_i,
   input  logic             irq_pend_i,
   input  logic             ext_irq_i,
   input  logic             rst_wake_i,
   input  logic             dly_long_i,
   output logic             cpu_ce_o,
   output logic             per_ce_o,
   output logic             osc_ce_o,
   output logic             tmr_ce_o,
   output logic             imask_clr_o,
   output logic             vec_irq_o,
   output logic             vec_rst_o,
   output logic             wdg_rst_o,
   output logic [1:0]       state_o
);
   pstate_e state_q, state_d;
   clk_en_t en;
   logic    go_halt, go_active, wdg_trip, dly_done;
   logic    imask_d, virq_d, vrst_d, wdg_d;
   logic    in_delay;

   assign in_delay = (state_q == PS_DELAY);

   halt_mode_sel #(
      .OP_W(OP_W), .HALT_OP(HALT_OP), .CKS_W(CKS_W), .HAS_AHALT(HAS_AHALT)
   ) u_mode (
      .in_run      (state_q == PS_RUN),
      .instr_valid (instr_valid_i),
      .instr_op    (instr_op_i),
      .tb_ie       (tb_ie_i),
      .ovf_ie      (ovf_ie_i),
      .ck_sel      (ck_sel_i),
      .wdg_active  (wdg_active_i),
      .go_halt     (go_halt),
      .go_active   (go_active),
      .wdg_trip    (wdg_trip)
   );

   halt_startup_cnt #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (rst_wake_i),
      .running  (in_delay),
      .long_sel (dly_long_i),
      .done     (dly_done)
   );

   halt_clk_en #(.OSC_IN_DELAY(1'b1)) u_ce (
      .st (state_q),
      .en (en)
   );

   always_comb begin
      state_d = state_q;
      imask_d = 1'b0;
      virq_d  = 1'b0;
      vrst_d  = 1'b0;
      wdg_d   = 1'b0;
      if (rst_wake_i) begin
         state_d = PS_DELAY;
      end else begin
         unique case (state_q)
            PS_RUN: begin
               wdg_d = wdg_trip;
               if (go_halt) begin
                  state_d = go_active ? PS_AHALT : PS_HALT;
                  imask_d = 1'b1;
               end
            end
            PS_HALT: begin
               if (ext_irq_i) begin
                  state_d = PS_RUN;
                  virq_d  = 1'b1;
               end
            end
            PS_AHALT: begin
               if (ext_irq_i || irq_pend_i) begin
                  state_d = PS_RUN;
                  virq_d  = 1'b1;
               end
            end
            PS_DELAY: begin
               if (dly_done) begin
                  state_d = PS_RUN;
                  vrst_d  = 1'b1;
               end
            end
            default: state_d = PS_RUN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= PS_RUN;
         imask_clr_o <= 1'b0;
         vec_irq_o   <= 1'b0;
         vec_rst_o   <= 1'b0;
         wdg_rst_o   <= 1'b0;
      end else begin
         state_q     <= state_d;
         imask_clr_o <= imask_d;
         vec_irq_o   <= virq_d;
         vec_rst_o   <= vrst_d;
         wdg_rst_o   <= wdg_d;
      end
   end

   assign cpu_ce_o = en.cpu;
   assign per_ce_o = en.per;
   assign osc_ce_o = en.osc;
   assign tmr_ce_o = en.tmr;
   assign state_o  = state_q;

   // R3: the mask-clear pulse marks the first cycle after leaving running
   a_r3_mask_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
      imask_clr_o |-> ((state_q == PS_HALT || state_q == PS_AHALT) && $past(state_q) == PS_RUN));
   // R4: active halt keeps only the oscillator and the timer clocked
   a_r4_ahalt_enables: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_AHALT) |-> (osc_ce_o && tmr_ce_o && !cpu_ce_o && !per_ce_o));
   // R5: plain halt gates every enable
   a_r5_halt_all_off: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_HALT) |-> !(osc_ce_o || tmr_ce_o || cpu_ce_o || per_ce_o));
   // R5: without an external interrupt or reset, plain halt persists
   a_r5_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_HALT && !ext_irq_i && !rst_wake_i) |=> (state_q == PS_HALT));
   // R6: interrupt vector request only on leaving a halt state
   a_r6_irq_vector: assert property (@(posedge clk) disable iff (!rst_n)
      vec_irq_o |-> (state_q == PS_RUN && ($past(state_q) == PS_HALT || $past(state_q) == PS_AHALT)));
   // R7: reset vector request only at the end of the delay
   a_r7_rst_vector: assert property (@(posedge clk) disable iff (!rst_n)
      vec_rst_o |-> (state_q == PS_RUN && $past(state_q) == PS_DELAY));
   // R8: the watchdog request leaves the core running
   a_r8_wdg_stays_run: assert property (@(posedge clk) disable iff (!rst_n)
      wdg_rst_o |-> (state_q == PS_RUN && $past(state_q) == PS_RUN));
   // R9: during the delay only the oscillator runs
   a_r9_delay_enables: assert property (@(posedge clk) disable iff (!rst_n)
      in_delay |-> (osc_ce_o && !tmr_ce_o && !cpu_ce_o && !per_ce_o));
   // R2: at most one request pulse at a time
   a_r2_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({imask_clr_o, vec_irq_o, vec_rst_o, wdg_rst_o}));
endmodule

// File: tb/halt_power_ctrl_tb.sv
module halt_power_ctrl_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       instr_valid_i = 1'b0;
   logic [7:0] instr_op_i = 8'h00;
   logic       tb_ie_i = 1'b0, ovf_ie_i = 1'b0;
   logic [1:0] ck_sel_i = 2'b00;
   logic       wdg_active_i = 1'b0, irq_pend_i = 1'b0, ext_irq_i = 1'b0;
   logic       rst_wake_i = 1'b0, dly_long_i = 1'b0;
   logic       cpu_ce_o, per_ce_o, osc_ce_o, tmr_ce_o;
   logic       imask_clr_o, vec_irq_o, vec_rst_o, wdg_rst_o;
   logic [1:0] state_o;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   halt_power_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .instr_valid_i(instr_valid_i), .instr_op_i(instr_op_i),
      .tb_ie_i(tb_ie_i), .ovf_ie_i(ovf_ie_i), .ck_sel_i(ck_sel_i),
      .wdg_active_i(wdg_active_i), .irq_pend_i(irq_pend_i), .ext_irq_i(ext_irq_i),
      .rst_wake_i(rst_wake_i), .dly_long_i(dly_long_i),
      .cpu_ce_o(cpu_ce_o), .per_ce_o(per_ce_o), .osc_ce_o(osc_ce_o), .tmr_ce_o(tmr_ce_o),
      .imask_clr_o(imask_clr_o), .vec_irq_o(vec_irq_o), .vec_rst_o(vec_rst_o),
      .wdg_rst_o(wdg_rst_o), .state_o(state_o)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // Behavioural reference: 0 run, 1 halt, 2 active halt, 3 delay
   int m_st = 0, m_cnt = 0;
   int m_imask = 0, m_virq = 0, m_vrst = 0, m_wdg = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_cnt = 0; m_imask = 0; m_virq = 0; m_vrst = 0; m_wdg = 0;
      end else begin
         int limit;
         bit act;
         limit = dly_long_i ? 4096 : 256;
         act = tb_ie_i || ovf_ie_i || (ck_sel_i != 0);
         m_imask = 0; m_virq = 0; m_vrst = 0; m_wdg = 0;
         if (rst_wake_i) begin
            m_st = 3; m_cnt = 0;
         end else if (m_st == 0) begin
            if (instr_valid_i && instr_op_i == 8'h8E) begin
               if (wdg_active_i && !act) m_wdg = 1;
               else begin m_st = act ? 2 : 1; m_imask = 1; end
            end
         end else if (m_st == 1) begin
            if (ext_irq_i) begin m_st = 0; m_virq = 1; end
         end else if (m_st == 2) begin
            if (ext_irq_i || irq_pend_i) begin m_st = 0; m_virq = 1; end
         end else begin
            if (m_cnt == limit - 1) begin m_st = 0; m_vrst = 1; end
            else m_cnt++;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R2", "state", int'(state_o), m_st);
         chk("R3", "imask_clr", int'(imask_clr_o), m_imask);
         chk("R4", "cpu_ce", int'(cpu_ce_o), (m_st == 0) ? 1 : 0);
         chk("R4", "per_ce", int'(per_ce_o), (m_st == 0) ? 1 : 0);
         chk("R5", "osc_ce", int'(osc_ce_o), (m_st == 1) ? 0 : 1);
         chk("R9", "tmr_ce", int'(tmr_ce_o), (m_st == 0 || m_st == 2) ? 1 : 0);
         chk("R6", "vec_irq", int'(vec_irq_o), m_virq);
         chk("R7", "vec_rst", int'(vec_rst_o), m_vrst);
         chk("R8", "wdg_rst", int'(wdg_rst_o), m_wdg);
      end
   end

   task automatic issue(input logic [7:0] op);
      @(negedge clk);
      instr_valid_i = 1'b1; instr_op_i = op;
      @(negedge clk);
      instr_valid_i = 1'b0; instr_op_i = 8'h00;
   endtask

   task automatic wake_pulse();
      @(negedge clk); rst_wake_i = 1'b1;
      @(negedge clk); rst_wake_i = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R2", "reset state", int'(state_o), 0);
      chk("R4", "reset cpu_ce", int'(cpu_ce_o), 1);

      // R1: a neighbouring opcode is ignored
      issue(8'h8F);
      chk("R1", "non-halt opcode", int'(state_o), 0);

      // R5: plain halt, pending non-external interrupt does not wake
      issue(8'h8E);
      chk("R2", "plain halt entry", int'(state_o), 1);
      irq_pend_i = 1'b1;
      repeat (5) @(negedge clk);
      chk("R5", "irq_pend ignored in halt", int'(state_o), 1);
      issue(8'h8E);
      chk("R1", "halt opcode inside halt", int'(state_o), 1);
      ext_irq_i = 1'b1;
      @(negedge clk);
      chk("R6", "ext wake state", int'(state_o), 0);
      chk("R6", "ext wake vector", int'(vec_irq_o), 1);
      ext_irq_i = 1'b0; irq_pend_i = 1'b0;

      // R6: active halt via timebase enable, woken by pending interrupt
      tb_ie_i = 1'b1;
      issue(8'h8E);
      chk("R2", "active halt entry", int'(state_o), 2);
      repeat (10) @(negedge clk);
      irq_pend_i = 1'b1;
      @(negedge clk);
      irq_pend_i = 1'b0;
      chk("R6", "active wake state", int'(state_o), 0);
      tb_ie_i = 1'b0;

      // R6: clock select alone enables active halt; interrupt pending at entry
      ck_sel_i = 2'b10; irq_pend_i = 1'b1;
      issue(8'h8E);
      chk("R6", "one cycle in active halt", int'(state_o), 2);
      @(negedge clk);
      chk("R6", "immediate return", int'(state_o), 0);
      irq_pend_i = 1'b0; ck_sel_i = 2'b00;

      // R8: watchdog with active halt off gives a reset request
      wdg_active_i = 1'b1;
      issue(8'h8E);
      chk("R8", "stays running", int'(state_o), 0);
      chk("R8", "wdg request", int'(wdg_rst_o), 1);
      // R8: with active halt enabled no request
      ovf_ie_i = 1'b1;
      issue(8'h8E);
      chk("R8", "active halt under watchdog", int'(state_o), 2);
      chk("R8", "no wdg request", int'(wdg_rst_o), 0);

      // R7 / R9: short delay from active halt
      wake_pulse();
      chk("R9", "delay osc", int'(osc_ce_o), 1);
      chk("R9", "delay cpu", int'(cpu_ce_o), 0);
      repeat (255) @(negedge clk);
      chk("R7", "short delay still counting", int'(state_o), 3);
      @(negedge clk);
      chk("R7", "short delay done", int'(state_o), 0);
      chk("R7", "reset vector", int'(vec_rst_o), 1);
      ovf_ie_i = 1'b0; wdg_active_i = 1'b0;

      // R10: long delay from plain halt, restarted in the middle
      dly_long_i = 1'b1;
      issue(8'h8E);
      chk("R2", "plain halt again", int'(state_o), 1);
      wake_pulse();
      repeat (2000) @(negedge clk);
      wake_pulse();
      repeat (4095) @(negedge clk);
      chk("R10", "restarted delay counting", int'(state_o), 3);
      @(negedge clk);
      chk("R10", "restarted delay done", int'(state_o), 0);
      chk("R7", "long reset vector", int'(vec_rst_o), 1);
      dly_long_i = 1'b0;

      repeat (4) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule